// File: doc/BRIEF.md
# DMA Transfer Engine with Access Modes

This block carries out a single DMA transfer of one source descriptor over a 64-bit data path. It reads from a source address and writes to a destination address over simple request/acknowledge memory ports. One memory beat carries at most eight bytes. A transfer is launched by a one-cycle `start_i` pulse. On that pulse the engine latches the whole configuration: pointer kind, access mode, burst kind, source and destination descriptors, and the write pattern. It then runs until the last byte is handled and signals completion with a single-cycle pulse.

There are three access modes. Read-write copies data. Read-only issues reads and never writes. Write-only never reads; it writes the latched 64-bit pattern for as many bytes as the destination descriptor holds. Addresses either increment by each transfer's length or stay fixed.

In memory pointer mode the destination may be split over several descriptors. When the current one runs dry and bytes remain, the engine asks for the next descriptor over a fetch port before it continues writing, splitting a beat if needed. A 32-bit running byte total is kept beside the engine and can be cleared bit by bit.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, all request outputs and all event pulses are 0, and `total_bytes_o` is 0.
- R2: In read-write mode with incrementing addresses (burst code 1), source bytes are read in beats of min(8, remaining) bytes from an address that advances by each beat's length. They are written unchanged to a destination address that advances by each write's length. Byte 0 of `wr_data_o` is the first byte of the write.
- R3: With a fixed burst (burst code 0, register pointer mode only), every read uses the source start address and every write uses the destination start address. Each beat is at most 8 bytes.
- R4: In read-only mode (mode code 2, register pointer mode) the engine reads the whole source length and issues no write.
- R5: In write-only mode (mode code 1, register pointer mode) the engine issues no read. It writes exactly the destination size in bytes, and byte k of the stream is byte (k mod 8) of the latched pattern.
- R6: In register pointer mode, outside write-only, the destination size has no effect: the source size alone sets the number of bytes written. Mode code 3 behaves as read-write.
- R7: In memory pointer mode (`ptr_mem_i` = 1) the mode and burst inputs are ignored, and the transfer runs as read-write with incrementing addresses.
- R8: In memory pointer mode no write is issued while the remaining destination size is 0. Instead `dsc_req_o` is raised, and writing resumes at the fetched descriptor's address and size. A beat that straddles two descriptors is split, with the remaining bytes shifted to byte 0 of `wr_data_o`.
- R9: `dst_done_o` pulses when a write brings a size-limited destination descriptor (memory pointer or write-only) to 0 with its interrupt flag set. In register pointer mode outside write-only and read-only, it pulses once at completion when the destination interrupt flag is set and at least one write occurred.
- R10: `xfer_done_o` pulses for exactly one cycle after the last byte. `src_done_o` pulses in that same cycle when the source interrupt flag was set. `busy_o` is 0 on the following cycle.
- R11: `total_bytes_o` (32 bits, wrapping) grows by each completed beat's length. A cycle with `tot_clr_i` high clears the bits set in `tot_clr_mask_i`.
- R12: A zero-length transfer issues no memory request and still gives `xfer_done_o` (and `src_done_o` if enabled).
- R13: `start_i` and all configuration inputs are ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, taken only when idle |
| ptr_mem_i | input | 1 | 1 = memory pointer mode, 0 = register pointer mode |
| mode_i | input | 2 | 0 read-write, 1 write-only, 2 read-only, 3 as read-write |
| burst_i | input | 1 | 0 fixed address, 1 incrementing |
| src_addr_i | input | 49 | Source start address |
| src_size_i | input | 30 | Source size in bytes |
| src_intr_i | input | 1 | Source completion event enable |
| dst_addr_i | input | 49 | First destination descriptor address |
| dst_size_i | input | 30 | First destination descriptor size |
| dst_intr_i | input | 1 | First destination descriptor event enable |
| pattern_i | input | 64 | Write-only data pattern |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | 49 | Read address |
| rd_len_o | output | 4 | Read length in bytes (1..8) |
| rd_ack_i | input | 1 | Read acknowledge with data |
| rd_data_i | input | 64 | Read data, byte 0 = byte at `rd_addr_o` |
| wr_req_o | output | 1 | Write request, held until acknowledged |
| wr_addr_o | output | 49 | Write address |
| wr_len_o | output | 4 | Write length in bytes (1..8) |
| wr_data_o | output | 64 | Write data, low bytes valid |
| wr_ack_i | input | 1 | Write acknowledge |
| dsc_req_o | output | 1 | Next destination descriptor request |
| dsc_ack_i | input | 1 | Descriptor acknowledge |
| dsc_addr_i | input | 49 | Fetched descriptor address |
| dsc_size_i | input | 30 | Fetched descriptor size |
| dsc_intr_i | input | 1 | Fetched descriptor event enable |
| tot_clr_i | input | 1 | Byte total clear strobe |
| tot_clr_mask_i | input | 32 | Bits of the total to clear |
| total_bytes_o | output | 32 | Running byte total |
| busy_o | output | 1 | Transfer in progress |
| src_done_o | output | 1 | Source completion event |
| dst_done_o | output | 1 | Destination descriptor completion event |
| xfer_done_o | output | 1 | Transfer completion pulse |

## Verification
The hardest situation to reach is a destination descriptor that runs out in the middle of an 8-byte beat. The split write must then resume after a descriptor fetch, with its data shifted. The memory-pointer stimulus therefore gives small, odd first descriptor sizes, and the bench's fetch responder hands out random sizes from 0 to 12, so splits, back-to-back fetches and zero-size descriptors all occur. Random acknowledge latencies and a mid-transfer start pulse with scrambled configuration cover the ignored-input case.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    MODE_RW   = 2'd0,
    MODE_WO   = 2'd1,
    MODE_RO   = 2'd2,
    MODE_RSVD = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_FETCH,
    ST_FINISH
  } eng_state_e;

  localparam logic BURST_FIXED = 1'b0;
  localparam logic BURST_INCR  = 1'b1;
endpackage

// File: rtl/dma_chunk_size.sv
module dma_chunk_size #(
  parameter int SIZE_W = 30,
  parameter int LEN_W  = 4
) (
  input  logic [SIZE_W-1:0] avail_i,
  input  logic [LEN_W-1:0]  cap_i,
  output logic [LEN_W-1:0]  len_o
);
  always_comb begin
    if (avail_i < SIZE_W'(cap_i)) len_o = avail_i[LEN_W-1:0];
    else                          len_o = cap_i;
  end
endmodule

// File: rtl/dma_byte_total.sv
module dma_byte_total #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_en_i,
  input  logic [LEN_W-1:0] add_len_i,
  input  logic             clr_en_i,
  input  logic [CNT_W-1:0] clr_mask_i,
  output logic [CNT_W-1:0] total_o
);
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] keep;
  logic [CNT_W-1:0] addend;

  assign keep   = clr_en_i ? ~clr_mask_i : {CNT_W{1'b1}};
  assign addend = add_en_i ? CNT_W'(add_len_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   total_q <= '0;
    else if (add_en_i || clr_en_i) total_q <= (total_q & keep) + addend;
  end

  assign total_o = total_q;

  // R11
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && (&clr_mask_i) && !add_en_i) |=> (total_o == '0));
  // R11
  add_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_en_i && !clr_en_i) |=> (total_o == $past(total_o) + CNT_W'($past(add_len_i))));
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int AW     = 49,
  parameter int SIZE_W = 30,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = $clog2(DATA_W / 8 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ptr_mem_i,
  input  logic [1:0]        mode_i,
  input  logic              burst_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [SIZE_W-1:0] src_size_i,
  input  logic              src_intr_i,
  input  logic [AW-1:0]     dst_addr_i,
  input  logic [SIZE_W-1:0] dst_size_i,
  input  logic              dst_intr_i,
  input  logic [DATA_W-1:0] pattern_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [LEN_W-1:0]  rd_len_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [LEN_W-1:0]  wr_len_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              dsc_req_o,
  input  logic              dsc_ack_i,
  input  logic [AW-1:0]     dsc_addr_i,
  input  logic [SIZE_W-1:0] dsc_size_i,
  input  logic              dsc_intr_i,
  input  logic              tot_clr_i,
  input  logic [CNT_W-1:0]  tot_clr_mask_i,
  output logic [CNT_W-1:0]  total_bytes_o,
  output logic              busy_o,
  output logic              src_done_o,
  output logic              dst_done_o,
  output logic              xfer_done_o
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam logic [LEN_W-1:0] BEAT_CAP = LEN_W'(BEAT_BYTES);

  eng_state_e        st_q;
  xfer_mode_e        mode_q;
  logic              mem_q, incr_q;
  logic [AW-1:0]     src_addr_q, dst_addr_q;
  logic [SIZE_W-1:0] rem_q, dst_rem_q;
  logic              src_intr_q, dst_intr_q, touched_q;
  logic [DATA_W-1:0] buf_q;
  logic [LEN_W-1:0]  off_q;

  xfer_mode_e        start_mode;
  logic              start_incr;
  logic [SIZE_W-1:0] start_len;
  logic [LEN_W-1:0]  beat_len, piece_len;
  logic              limit_dst, need_fetch, wr_fire, beat_end, add_en;

  assign start_mode = ptr_mem_i ? MODE_RW : xfer_mode_e'(mode_i);
  assign start_incr = ptr_mem_i ? BURST_INCR : burst_i;
  assign start_len  = (start_mode == MODE_WO) ? dst_size_i : src_size_i;

  assign limit_dst  = mem_q || (mode_q == MODE_WO);
  assign need_fetch = mem_q && (dst_rem_q == '0);

  // rem_q only moves at beat boundaries, so this is the current beat length
  dma_chunk_size #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_beat (
    .avail_i (rem_q),
    .cap_i   (BEAT_CAP),
    .len_o   (beat_len)
  );

  dma_chunk_size #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_piece (
    .avail_i (limit_dst ? dst_rem_q : {SIZE_W{1'b1}}),
    .cap_i   (beat_len - off_q),
    .len_o   (piece_len)
  );

  assign rd_req_o  = (st_q == ST_READ);
  assign rd_addr_o = src_addr_q;
  assign rd_len_o  = beat_len;
  assign wr_req_o  = (st_q == ST_WRITE) && !need_fetch;
  assign wr_addr_o = dst_addr_q;
  assign wr_len_o  = piece_len;
  assign wr_data_o = buf_q >> {off_q, 3'b000};
  assign dsc_req_o = (st_q == ST_FETCH);
  assign wr_fire   = wr_req_o && wr_ack_i;
  assign beat_end  = (off_q + piece_len) == beat_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mode_q     <= MODE_RW;
      mem_q      <= 1'b0;
      incr_q     <= BURST_INCR;
      src_addr_q <= '0;
      dst_addr_q <= '0;
      rem_q      <= '0;
      dst_rem_q  <= '0;
      src_intr_q <= 1'b0;
      dst_intr_q <= 1'b0;
      touched_q  <= 1'b0;
      buf_q      <= '0;
      off_q      <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mode_q     <= start_mode;
          mem_q      <= ptr_mem_i;
          incr_q     <= start_incr;
          src_addr_q <= src_addr_i;
          dst_addr_q <= dst_addr_i;
          rem_q      <= start_len;
          dst_rem_q  <= dst_size_i;
          src_intr_q <= src_intr_i;
          dst_intr_q <= dst_intr_i;
          touched_q  <= 1'b0;
          buf_q      <= pattern_i;
          off_q      <= '0;
          if (start_len == '0)            st_q <= ST_FINISH;
          else if (start_mode == MODE_WO) st_q <= ST_WRITE;
          else                            st_q <= ST_READ;
        end
        ST_READ: if (rd_ack_i) begin
          buf_q <= rd_data_i;
          off_q <= '0;
          if (incr_q == BURST_INCR) src_addr_q <= src_addr_q + AW'(beat_len);
          if (mode_q == MODE_RO) begin
            rem_q <= rem_q - SIZE_W'(beat_len);
            st_q  <= (rem_q == SIZE_W'(beat_len)) ? ST_FINISH : ST_READ;
          end else begin
            st_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (need_fetch) begin
            st_q <= ST_FETCH;
          end else if (wr_ack_i) begin
            touched_q <= 1'b1;
            if (incr_q == BURST_INCR) dst_addr_q <= dst_addr_q + AW'(piece_len);
            if (limit_dst) dst_rem_q <= dst_rem_q - SIZE_W'(piece_len);
            if (beat_end) begin
              off_q <= '0;
              rem_q <= rem_q - SIZE_W'(beat_len);
              if (rem_q == SIZE_W'(beat_len)) st_q <= ST_FINISH;
              else if (mode_q == MODE_WO)     st_q <= ST_WRITE;
              else                            st_q <= ST_READ;
            end else begin
              off_q <= off_q + piece_len;
            end
          end
        end
        ST_FETCH: if (dsc_ack_i) begin
          dst_addr_q <= dsc_addr_i;
          dst_rem_q  <= dsc_size_i;
          dst_intr_q <= dsc_intr_i;
          st_q       <= ST_WRITE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign add_en = (rd_req_o && rd_ack_i && mode_q == MODE_RO) || (wr_fire && beat_end);

  dma_byte_total #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_total (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_en_i   (add_en),
    .add_len_i  (beat_len),
    .clr_en_i   (tot_clr_i),
    .clr_mask_i (tot_clr_mask_i),
    .total_o    (total_bytes_o)
  );

  assign busy_o      = (st_q != ST_IDLE);
  assign xfer_done_o = (st_q == ST_FINISH);
  assign src_done_o  = (st_q == ST_FINISH) && src_intr_q;
  assign dst_done_o  = (wr_fire && limit_dst && dst_intr_q && (dst_rem_q == SIZE_W'(piece_len)))
                    || ((st_q == ST_FINISH) && !limit_dst && (mode_q != MODE_RO)
                        && touched_q && dst_intr_q);

  // R2
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_o, wr_req_o, dsc_req_o}));
  // R2
  wr_len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_len_o != '0 && wr_len_o <= BEAT_CAP));
  // R3
  fixed_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && incr_q == BURST_FIXED) |=> $stable(wr_addr_o));
  // R4
  ro_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == MODE_RO) |-> !wr_req_o);
  // R5
  wo_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == MODE_WO) |-> !rd_req_o);
  // R7
  mem_forces_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_q) |-> (incr_q == BURST_INCR && mode_q == MODE_RW));
  // R8
  mem_dst_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && limit_dst) |-> (SIZE_W'(wr_len_o) <= dst_rem_q));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |=> (!xfer_done_o && !busy_o));
endmodule

// File: tb/dma_xfer_engine_tb_top.sv
module dma_xfer_engine_tb_top;
  localparam int AW = 49;
  localparam int SW = 30;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, ptr_mem = 1'b0, burst = 1'b1;
  logic [1:0]    mode = 2'd0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0, dsc_addr = '0;
  logic [SW-1:0] src_size = '0, dst_size = '0, dsc_size = '0;
  logic          src_intr = 1'b0, dst_intr = 1'b0, dsc_intr = 1'b0;
  logic [DW-1:0] pattern = '0, rd_data = '0;
  logic          rd_ack = 1'b0, wr_ack = 1'b0, dsc_ack = 1'b0;
  logic          tot_clr = 1'b0;
  logic [31:0]   tot_mask = '0;

  logic          rd_req, wr_req, dsc_req, busy, src_done, dst_done, xfer_done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [3:0]    rd_len, wr_len;
  logic [DW-1:0] wr_data;
  logic [31:0]   total;

  int checks = 0;
  int failures = 0;
  logic [31:0] tot_exp = '0;

  always #10 clk = ~clk;

  dma_xfer_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ptr_mem_i(ptr_mem), .mode_i(mode),
    .burst_i(burst), .src_addr_i(src_addr), .src_size_i(src_size), .src_intr_i(src_intr),
    .dst_addr_i(dst_addr), .dst_size_i(dst_size), .dst_intr_i(dst_intr), .pattern_i(pattern),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_len_o(rd_len), .rd_ack_i(rd_ack),
    .rd_data_i(rd_data), .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_len_o(wr_len),
    .wr_data_o(wr_data), .wr_ack_i(wr_ack), .dsc_req_o(dsc_req), .dsc_ack_i(dsc_ack),
    .dsc_addr_i(dsc_addr), .dsc_size_i(dsc_size), .dsc_intr_i(dsc_intr),
    .tot_clr_i(tot_clr), .tot_clr_mask_i(tot_mask), .total_bytes_o(total),
    .busy_o(busy), .src_done_o(src_done), .dst_done_o(dst_done), .xfer_done_o(xfer_done)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  function automatic logic [7:0] src_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [AW-1:0] rnd_addr();
    return AW'({$urandom, $urandom});
  endfunction

  task automatic run_xfer(input bit m, input logic [1:0] md, input bit b,
                          input logic [AW-1:0] sa, input logic [SW-1:0] ss, input bit si,
                          input logic [AW-1:0] da, input logic [SW-1:0] ds, input bit di,
                          input logic [DW-1:0] pat, input bit disturb);
    logic [1:0]    emode;
    bit            eincr, limit, done;
    logic [SW-1:0] len, drem;
    logic [AW-1:0] dcur, exp_a;
    logic [DW-1:0] exp_d, msk;
    int            n_wr, n_rd, got_x, got_s, got_d, exp_dd, wait_c, guard, piece, bend;
    string         ra, rp, rdt;
    emode  = m ? 2'd0 : (md == 2'd3 ? 2'd0 : md);
    eincr  = m ? 1'b1 : b;
    len    = (emode == 2'd1) ? ds : ss;
    limit  = m || (emode == 2'd1);
    dcur   = da;
    drem   = ds;
    n_wr = 0; n_rd = 0; got_x = 0; got_s = 0; got_d = 0; exp_dd = 0; wait_c = 0; guard = 0;
    done = 1'b0;
    ra  = m ? "R7" : (eincr ? "R2" : "R3");
    rp  = m ? "R8" : (emode == 2'd1 ? "R5" : "R6");
    rdt = (emode == 2'd1) ? "R5" : (m ? "R8" : "R2");

    @(negedge clk);
    start = 1'b1; ptr_mem = m; mode = md; burst = b; src_addr = sa; src_size = ss;
    src_intr = si; dst_addr = da; dst_size = ds; dst_intr = di; pattern = pat;
    @(negedge clk);
    if (disturb) begin
      // R13: scrambled config with start held while busy
      ptr_mem = ~m; mode = 2'd1; burst = ~b; src_addr = rnd_addr(); src_size = 30'd3;
      dst_addr = rnd_addr(); dst_size = 30'd1; pattern = ~pat; src_intr = ~si;
    end else begin
      start = 1'b0;
    end
    #1;
    while (!done && guard < 3000) begin
      if (xfer_done) begin got_x++; done = 1'b1; end
      if (src_done) got_s++;
      if (dst_done) got_d++;
      if (!done) begin
        if (rd_req) begin
          if (emode == 2'd1) chk("R5", "read in write-only", 1, 0);
          if (wait_c > 0) wait_c--;
          else begin
            exp_a = eincr ? sa + AW'(8 * n_rd) : sa;
            chk(ra, "rd_addr", 64'(rd_addr), 64'(exp_a));
            chk(ra, "rd_len", 64'(rd_len), 64'((len - SW'(8 * n_rd)) < 8 ? len - SW'(8 * n_rd) : 8));
            for (int k = 0; k < 8; k++) rd_data[8*k +: 8] = src_byte(rd_addr + AW'(k));
            rd_ack = 1'b1;
            n_rd++;
            wait_c = $urandom % 3;
          end
        end else if (wr_req) begin
          if (emode == 2'd2) chk("R4", "write in read-only", 1, 0);
          if (wait_c > 0) wait_c--;
          else begin
            bend  = ((n_wr / 8) + 1) * 8;
            if (bend > int'(len)) bend = int'(len);
            piece = bend - n_wr;
            if (limit && int'(drem) < piece) piece = int'(drem);
            chk(rp, "wr_len", 64'(wr_len), 64'(piece));
            chk(ra, "wr_addr", 64'(wr_addr), 64'(eincr ? dcur : da));
            exp_d = '0; msk = '0;
            for (int k = 0; k < piece; k++) begin
              if (emode == 2'd1) exp_d[8*k +: 8] = pat[8*((n_wr + k) % 8) +: 8];
              else exp_d[8*k +: 8] = src_byte(eincr ? sa + AW'(n_wr + k) : sa + AW'((n_wr + k) % 8));
              msk[8*k +: 8] = 8'hFF;
            end
            chk(rdt, "wr_data", wr_data & msk, exp_d);
            wr_ack = 1'b1;
            #1;
            if (dst_done) got_d++;
            n_wr += piece;
            if (eincr) dcur = dcur + AW'(piece);
            if (limit) begin
              drem = drem - SW'(piece);
              if (drem == '0 && di) exp_dd++;
            end
            wait_c = $urandom % 3;
          end
        end else if (dsc_req) begin
          if (!m) chk("R8", "fetch outside memory pointer mode", 1, 0);
          if (wait_c > 0) wait_c--;
          else begin
            dsc_addr = rnd_addr();
            dsc_size = SW'($urandom % 13);
            dsc_intr = $urandom % 2;
            dcur = dsc_addr; drem = dsc_size; di = dsc_intr;
            dsc_ack = 1'b1;
            wait_c = $urandom % 3;
          end
        end
        @(negedge clk);
        rd_ack = 1'b0; wr_ack = 1'b0; dsc_ack = 1'b0; start = 1'b0;
        #1;
        guard++;
      end
    end
    if (!limit && emode != 2'd2 && len != '0 && di) exp_dd++;
    tot_exp = tot_exp + 32'(len);
    chk("R10", "xfer_done count", 64'(got_x), 1);
    chk("R10", "src_done count", 64'(got_s), 64'(si ? 1 : 0));
    chk("R9", "dst_done count", 64'(got_d), 64'(exp_dd));
    chk(emode == 2'd2 ? "R4" : "R6", "bytes written", 64'(n_wr), 64'(emode == 2'd2 ? 0 : len));
    chk(emode == 2'd1 ? "R5" : "R2", "read beats", 64'(n_rd),
        64'(emode == 2'd1 ? 0 : (len + 7) / 8));
    chk("R11", "total", 64'(total), 64'(tot_exp));
    @(negedge clk); #1;
    chk("R10", "idle after done", 64'({busy, xfer_done}), 0);
  endtask

  task automatic clear_total(input logic [31:0] m);
    @(negedge clk);
    tot_clr = 1'b1; tot_mask = m;
    @(negedge clk);
    tot_clr = 1'b0;
    #1;
    tot_exp = tot_exp & ~m;
    chk("R11", "total after clear", 64'(total), 64'(tot_exp));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk("R1", "reset outputs", 64'({busy, rd_req, wr_req, dsc_req, xfer_done, src_done, dst_done}), 0);
    chk("R1", "reset total", 64'(total), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "idle after release", 64'({busy, rd_req, wr_req, dsc_req}), 0);

    // R2/R6: read-write incrementing, tiny dst size ignored
    run_xfer(0, 2'd0, 1, 49'h1_0000_0103, 30'd21, 1, 49'h0_2000_0005, 30'd3, 1, 64'h0, 0);
    // R3: fixed burst
    run_xfer(0, 2'd0, 0, 49'h0_0000_4440, 30'd19, 0, 49'h0_0000_9000, 30'd0, 0, 64'h0, 0);
    // R4: read-only
    run_xfer(0, 2'd2, 1, 49'h0_0300_0011, 30'd17, 1, 49'h0_0000_0100, 30'd50, 1, 64'h0, 0);
    // R5: write-only, source size ignored
    run_xfer(0, 2'd1, 1, 49'h0_0000_0000, 30'd40, 0, 49'h1_FFFF_FFF0, 30'd13, 1,
             64'h8877_6655_4433_2211, 0);
    // R5/R3: write-only fixed
    run_xfer(0, 2'd1, 0, 49'h0, 30'd0, 1, 49'h0_0000_0800, 30'd11, 0, 64'hDEAD_BEEF_CAFE_F00D, 0);
    // R6: mode code 3 as read-write
    run_xfer(0, 2'd3, 1, 49'h0_0000_0700, 30'd9, 0, 49'h0_0001_0000, 30'd0, 1, 64'h0, 0);
    // R7/R8: memory pointer, mode/burst forced, small odd dst descriptor
    run_xfer(1, 2'd2, 0, 49'h0_0000_5000, 30'd30, 1, 49'h0_0006_0000, 30'd5, 1, 64'h0, 0);
    // R8: first dst descriptor empty
    run_xfer(1, 2'd0, 1, 49'h0_0000_6001, 30'd14, 0, 49'h0_0007_0000, 30'd0, 1, 64'h0, 0);
    // R12: zero-length transfers
    run_xfer(0, 2'd0, 1, 49'h100, 30'd0, 1, 49'h200, 30'd8, 1, 64'h0, 0);
    run_xfer(0, 2'd1, 1, 49'h100, 30'd9, 0, 49'h200, 30'd0, 1, 64'h5, 0);
    // R13: start and config changes while busy
    run_xfer(0, 2'd0, 1, 49'h0_0000_0A00, 30'd23, 1, 49'h0_0000_0B00, 30'd0, 0, 64'h0, 1);
    // R11: partial and full clear
    clear_total(32'h0000_00F0);
    clear_total(32'hFFFF_FFFF);

    for (int i = 0; i < 40; i++) begin
      bit rm;
      rm = $urandom % 2;
      run_xfer(rm, 2'($urandom % 4), $urandom % 2, rnd_addr(), SW'($urandom % 41),
               $urandom % 2, rnd_addr(), SW'(rm ? $urandom % 13 : $urandom % 41),
               $urandom % 2, {$urandom, $urandom}, (i % 7) == 3);
    end
    clear_total(32'h5A5A_A5A5);
    finish_run();
  end
endmodule